// File: doc/BRIEF.md
# Divided Clock Bank with Programmable Phase Skew

This block produces the four clock outputs of one bank in a multi-phase clock generator. It runs on a fast clock in which each cycle is one time unit (tick). A one-tick alignment pulse marks the start of every nominal period of N ticks. From three-level selects the bank derives a divide ratio and a signed skew in ticks, and it drives four outputs named A0, A1, B0 and B1. Each output is a clock with a period of divide × N ticks and a 50% duty cycle. Its rising edge is placed at the chosen skew from the point where the divided period starts. A third select sets the polarity: all outputs true, all outputs inverted, or the A1 and B1 outputs inverted against their partners.

A parameter picks one of three bank kinds. The standard kind offers skews of -4 to +4 ticks. The extended kind offers -8, -7, -6, 0, +6, +7 and +8 ticks, and it can also copy the skew that a peer bank applies (peer 1 or peer 2). The feedback kind has a single skew select with the values -4, 0 and +4. Each bank presents its active skew on `skew_out` so that a neighbouring bank of the extended kind can copy it. Every select is sampled only at an alignment pulse, so the configuration changes at period boundaries.

Top module: `skew_div_bank`

## Requirements
- R1: While `rst` is high, all four outputs are low and `skew_out` is 0, whatever the selects are set to.
- R2: The divide selects form the index 3×`div_hi`+`div_lo` (levels LOW=0, MID=1, HIGH=2). Index 0..8 gives ratios 1, 2, 3, 4, 5, 6, 8, 10 and 12. The output period is ratio × N ticks.
- R3: Within each output period, a true-polarity output is high for exactly half the ticks and low for the other half.
- R4: In the standard kind (BANK_KIND=0) the skew is 3×`skw_hi`+`skw_lo` minus 4 ticks.
- R5: In the extended kind (BANK_KIND=1) skew index 0..8 gives -8, -7, -6, the value of `peer1_skew`, 0, the value of `peer2_skew`, +6, +7 and +8 ticks. The peer values lie within -8..+8.
- R6: In the feedback kind (BANK_KIND=2) only `skw_lo` is used: LOW gives -4, MID gives 0 and HIGH gives +4 ticks. `skw_hi` has no effect.
- R7: `rng_sel` sets N to N_BASE when LOW, 2×N_BASE when MID and 4×N_BASE when HIGH (16, 32 and 64 with the default N_BASE of 16).
- R8: When `inv_sel` is MID, all outputs are true. When it is HIGH, all four are inverted. When it is LOW, A0 and B0 are true and A1 and B1 are inverted. Polarity applies together with any divide ratio and skew.
- R9: A select code of 3 acts as MID on every select input.
- R10: The selects and peer skews are captured only at an alignment pulse. A change that affects only the skew keeps the output period running. A change of the divide ratio or of N restarts the divided period at that pulse, and so does the first pulse after reset.
- R11: Take the edge that samples the alignment pulse starting a divided period as tick 0, with period P and skew s. The true-polarity output after edge k+1 is high exactly when (k − s) mod P < P/2. Every later alignment pulse returns the tick count within the nominal period to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, one cycle per time unit |
| rst | input | 1 | Synchronous active-high reset |
| align | input | 1 | One-tick pulse at each nominal-period edge |
| rng_sel | input | 2 | Nominal period select (ternary) |
| div_hi | input | 2 | Divide select, upper digit |
| div_lo | input | 2 | Divide select, lower digit |
| skw_hi | input | 2 | Skew select, upper digit |
| skw_lo | input | 2 | Skew select, lower digit |
| inv_sel | input | 2 | Polarity select |
| peer1_skew | input | SKW_W | Active skew of peer bank 1 (signed ticks) |
| peer2_skew | input | SKW_W | Active skew of peer bank 2 (signed ticks) |
| q_a0 | output | 1 | Bank output A0 |
| q_a1 | output | 1 | Bank output A1 |
| q_b0 | output | 1 | Bank output B0 |
| q_b1 | output | 1 | Bank output B1 |
| skew_out | output | SKW_W | Skew applied by this bank (signed ticks) |

## Verification
The embedded assertions check on every cycle that the captured configuration only moves at an alignment pulse and always holds a legal divide ratio, a legal N and a code-3-free polarity. They also check that the tick and epoch counters stay below N and the ratio, that a pulse returns the tick count to zero, that a feedback bank never holds a skew other than -4, 0 or +4, and that the A0/A1 relation matches the polarity mode one cycle later. What only the scenarios can show is the waveform itself: the exact edge positions for each ratio and skew code, the wrap of negative skews to the end of the period, copied peer skews, the 50% high count, and a skew-only change that keeps the period running.

// File: rtl/skew_div_pkg.sv
package skew_div_pkg;

  localparam logic [1:0] LVL_LO  = 2'd0;
  localparam logic [1:0] LVL_MID = 2'd1;
  localparam logic [1:0] LVL_HI  = 2'd2;

  localparam int KIND_STD = 0;
  localparam int KIND_EXT = 1;
  localparam int KIND_FB  = 2;

  // Code 3 is not a legal level; it is read as the open (middle) level.
  function automatic logic [1:0] lvl_fix(input logic [1:0] v);
    logic [1:0] r;
    r = (v == 2'd3) ? LVL_MID : v;
    return r;
  endfunction

  // Two ternary digits to a 0..8 index, upper digit first.
  function automatic logic [3:0] pair_index(input logic [1:0] hi, input logic [1:0] lo);
    logic [3:0] r;
    r = ({2'b00, lvl_fix(hi)} * 4'd3) + {2'b00, lvl_fix(lo)};
    return r;
  endfunction

  // Non-contiguous divide ratios selected by the 0..8 index.
  function automatic logic [3:0] div_ratio(input logic [3:0] idx);
    logic [3:0] r;
    case (idx)
      4'd0:    r = 4'd1;
      4'd1:    r = 4'd2;
      4'd2:    r = 4'd3;
      4'd3:    r = 4'd4;
      4'd4:    r = 4'd5;
      4'd5:    r = 4'd6;
      4'd6:    r = 4'd8;
      4'd7:    r = 4'd10;
      4'd8:    r = 4'd12;
      default: r = 4'd1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/sdb_skew_decode.sv
module sdb_skew_decode
  import skew_div_pkg::*;
#(
  parameter int KIND = KIND_EXT,
  parameter int SW   = 5
) (
  input  logic [1:0]           sel_hi,
  input  logic [1:0]           sel_lo,
  input  logic signed [SW-1:0] peer1,
  input  logic signed [SW-1:0] peer2,
  output logic signed [SW-1:0] skew
);

  logic [3:0] idx;
  assign idx = pair_index(sel_hi, sel_lo);

  generate
    if (KIND == KIND_FB) begin : g_fb
      // Single select, coarse three-way phase.
      always_comb begin
        case (lvl_fix(sel_lo))
          LVL_LO:  skew = SW'(-4);
          LVL_HI:  skew = SW'(4);
          default: skew = '0;
        endcase
      end
    end else if (KIND == KIND_EXT) begin : g_ext
      // Wide offsets plus two positions that copy a peer bank.
      always_comb begin
        case (idx)
          4'd0:    skew = SW'(-8);
          4'd1:    skew = SW'(-7);
          4'd2:    skew = SW'(-6);
          4'd3:    skew = peer1;
          4'd5:    skew = peer2;
          4'd6:    skew = SW'(6);
          4'd7:    skew = SW'(7);
          4'd8:    skew = SW'(8);
          default: skew = '0;
        endcase
      end
    end else begin : g_std
      // Linear map: index minus four.
      always_comb begin
        skew = SW'($signed({1'b0, idx})) - SW'(4);
      end
    end
  endgenerate

endmodule

// File: rtl/sdb_phase_ctr.sv
module sdb_phase_ctr #(
  parameter int TW = 6,
  parameter int EW = 4,
  parameter int PW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          align,
  input  logic          restart,
  input  logic [EW-1:0] div_nxt,
  input  logic [TW:0]   n_nxt,
  input  logic [EW-1:0] div_cur,
  input  logic [TW:0]   n_cur,
  output logic [PW-1:0] pos
);

  logic [TW-1:0] tick;
  logic [EW-1:0] epoch;
  logic [EW:0]   ep_p1;
  logic [EW-1:0] ep_adv;
  logic          tick_last;

  assign ep_p1     = {1'b0, epoch} + 1'b1;
  assign ep_adv    = (ep_p1 >= {1'b0, div_nxt}) ? '0 : ep_p1[EW-1:0];
  assign tick_last = ({1'b0, tick} == (n_nxt - 1'b1));

  always_ff @(posedge clk) begin
    if (rst) begin
      tick  <= '0;
      epoch <= '0;
    end else if (align) begin
      tick  <= '0;
      epoch <= restart ? '0 : ep_adv;
    end else if (tick_last) begin
      tick  <= '0;
      epoch <= ep_adv;
    end else begin
      tick  <= tick + 1'b1;
    end
  end

  // Position inside the divided period: whole nominal periods plus ticks.
  assign pos = (PW'(epoch) * PW'(n_cur)) + PW'(tick);

  AST_TICK_BELOW_N: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, tick} < n_cur)); // R7
  AST_EPOCH_BELOW_DIV: assert property (@(posedge clk) disable iff (rst)
    (epoch < div_cur)); // R2
  AST_ALIGN_CLEARS_TICK: assert property (@(posedge clk) disable iff (rst)
    align |=> (tick == '0)); // R11

endmodule

// File: rtl/sdb_wave_out.sv
module sdb_wave_out
  import skew_div_pkg::*;
#(
  parameter int PW = 10,
  parameter int SW = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [PW-1:0]        pos,
  input  logic [PW-1:0]        period,
  input  logic signed [SW-1:0] skew,
  input  logic [1:0]           inv,
  output logic [3:0]           q
);

  localparam int DW = PW + 2;

  logic signed [DW-1:0] per_s, half_s, d_raw, d_mod;
  logic                 hi, flip_true, flip_comp;

  assign per_s  = $signed({2'b00, period});
  assign half_s = per_s >>> 1;
  assign d_raw  = $signed({2'b00, pos}) - DW'(skew);

  // Skew magnitude is below the smallest period, so one correction suffices.
  always_comb begin
    if (d_raw[DW-1])
      d_mod = d_raw + per_s;
    else if (d_raw >= per_s)
      d_mod = d_raw - per_s;
    else
      d_mod = d_raw;
  end

  assign hi        = (d_mod < half_s);
  assign flip_true = (inv == LVL_HI);
  assign flip_comp = (inv == LVL_HI) || (inv == LVL_LO);

  // q[0]=A0, q[1]=A1, q[2]=B0, q[3]=B1
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      q[0] <= hi ^ flip_true;
      q[2] <= hi ^ flip_true;
      q[1] <= hi ^ flip_comp;
      q[3] <= hi ^ flip_comp;
    end
  end

  AST_COMPL_PAIR: assert property (@(posedge clk) disable iff (rst)
    (inv == LVL_LO) |=> (q[0] != q[1])); // R8
  AST_SAME_POLARITY: assert property (@(posedge clk) disable iff (rst)
    (inv != LVL_LO) |=> (q[0] == q[1])); // R8

endmodule

// File: rtl/skew_div_bank.sv
module skew_div_bank
  import skew_div_pkg::*;
#(
  parameter int BANK_KIND = KIND_EXT,
  parameter int N_BASE    = 16,
  parameter int SKW_W     = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    align,
  input  logic [1:0]              rng_sel,
  input  logic [1:0]              div_hi,
  input  logic [1:0]              div_lo,
  input  logic [1:0]              skw_hi,
  input  logic [1:0]              skw_lo,
  input  logic [1:0]              inv_sel,
  input  logic signed [SKW_W-1:0] peer1_skew,
  input  logic signed [SKW_W-1:0] peer2_skew,
  output logic                    q_a0,
  output logic                    q_a1,
  output logic                    q_b0,
  output logic                    q_b1,
  output logic signed [SKW_W-1:0] skew_out
);

  localparam int N_MAX   = N_BASE * 4;
  localparam int TW      = $clog2(N_MAX);
  localparam int DIV_MAX = 12;
  localparam int EW      = $clog2(DIV_MAX + 1);
  localparam int P_MAX   = N_MAX * DIV_MAX;
  localparam int PW      = $clog2(P_MAX + 1);

  // Decoded selects (take effect only at align)
  logic [EW-1:0]          div_dec;
  logic [TW:0]            n_dec;
  logic signed [SKW_W-1:0] skew_dec;

  assign div_dec = EW'(div_ratio(pair_index(div_hi, div_lo)));
  assign n_dec   = (TW+1)'(N_BASE) << lvl_fix(rng_sel);

  sdb_skew_decode #(.KIND(BANK_KIND), .SW(SKW_W)) u_skew_dec (
    .sel_hi (skw_hi),
    .sel_lo (skw_lo),
    .peer1  (peer1_skew),
    .peer2  (peer2_skew),
    .skew   (skew_dec)
  );

  // Captured configuration
  logic [EW-1:0]           div_cur;
  logic [TW:0]             n_cur;
  logic signed [SKW_W-1:0] skew_cur;
  logic [1:0]              inv_cur;
  logic                    first_pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cur       <= EW'(1);
      n_cur         <= (TW+1)'(N_BASE * 2);
      skew_cur      <= '0;
      inv_cur       <= LVL_MID;
      first_pending <= 1'b1;
    end else if (align) begin
      div_cur       <= div_dec;
      n_cur         <= n_dec;
      skew_cur      <= skew_dec;
      inv_cur       <= lvl_fix(inv_sel);
      first_pending <= 1'b0;
    end
  end

  logic          restart;
  logic [EW-1:0] div_nxt;
  logic [TW:0]   n_nxt;
  logic [PW-1:0] pos, period;
  logic [3:0]    q_w;

  assign restart = align && (first_pending || (div_dec != div_cur) || (n_dec != n_cur));
  assign div_nxt = align ? div_dec : div_cur;
  assign n_nxt   = align ? n_dec : n_cur;
  assign period  = PW'(div_cur) * PW'(n_cur);

  sdb_phase_ctr #(.TW(TW), .EW(EW), .PW(PW)) u_ctr (
    .clk     (clk),
    .rst     (rst),
    .align   (align),
    .restart (restart),
    .div_nxt (div_nxt),
    .n_nxt   (n_nxt),
    .div_cur (div_cur),
    .n_cur   (n_cur),
    .pos     (pos)
  );

  sdb_wave_out #(.PW(PW), .SW(SKW_W)) u_wave (
    .clk    (clk),
    .rst    (rst),
    .pos    (pos),
    .period (period),
    .skew   (skew_cur),
    .inv    (inv_cur),
    .q      (q_w)
  );

  assign q_a0     = q_w[0];
  assign q_a1     = q_w[1];
  assign q_b0     = q_w[2];
  assign q_b1     = q_w[3];
  assign skew_out = skew_cur;

  AST_CFG_ONLY_AT_ALIGN: assert property (@(posedge clk) disable iff (rst)
    !align |=> ($stable(div_cur) && $stable(n_cur) && $stable(skew_cur) && $stable(inv_cur))); // R10
  AST_DIV_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (div_cur inside {EW'(1), EW'(2), EW'(3), EW'(4), EW'(5), EW'(6), EW'(8), EW'(10), EW'(12)})); // R2
  AST_RANGE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    ((n_cur == (TW+1)'(N_BASE)) || (n_cur == (TW+1)'(N_BASE * 2)) || (n_cur == (TW+1)'(N_BASE * 4)))); // R7
  AST_INV_NO_CODE3: assert property (@(posedge clk) disable iff (rst)
    (inv_cur != 2'd3)); // R9

  generate
    if (BANK_KIND == KIND_FB) begin : g_fb_chk
      AST_FB_SKEW_SET: assert property (@(posedge clk) disable iff (rst)
        ((skew_cur == SKW_W'(-4)) || (skew_cur == '0) || (skew_cur == SKW_W'(4)))); // R6
    end
  endgenerate

endmodule

// File: tb/skew_div_bank_bench.sv
`timescale 1ns/1ps
module skew_div_bank_bench;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst, align;
  logic [1:0]        rng, dh, dl, sh, sl, iv;
  logic signed [4:0] p1, p2;
  logic [3:0]        qx, qs, qf;
  logic signed [4:0] sx, ss, sf;

  int  errs   = 0;
  int  checks = 0;
  bit  done   = 1'b0;

  skew_div_bank #(.BANK_KIND(1)) u_skew_div_bank (
    .clk(clk), .rst(rst), .align(align), .rng_sel(rng), .div_hi(dh), .div_lo(dl),
    .skw_hi(sh), .skw_lo(sl), .inv_sel(iv), .peer1_skew(p1), .peer2_skew(p2),
    .q_a0(qx[0]), .q_a1(qx[1]), .q_b0(qx[2]), .q_b1(qx[3]), .skew_out(sx));

  skew_div_bank #(.BANK_KIND(0)) u_skew_div_bank_std (
    .clk(clk), .rst(rst), .align(align), .rng_sel(rng), .div_hi(dh), .div_lo(dl),
    .skw_hi(sh), .skw_lo(sl), .inv_sel(iv), .peer1_skew(p1), .peer2_skew(p2),
    .q_a0(qs[0]), .q_a1(qs[1]), .q_b0(qs[2]), .q_b1(qs[3]), .skew_out(ss));

  skew_div_bank #(.BANK_KIND(2)) u_skew_div_bank_fb (
    .clk(clk), .rst(rst), .align(align), .rng_sel(rng), .div_hi(dh), .div_lo(dl),
    .skw_hi(sh), .skw_lo(sl), .inv_sel(iv), .peer1_skew(p1), .peer2_skew(p2),
    .q_a0(qf[0]), .q_a1(qf[1]), .q_b0(qf[2]), .q_b1(qf[3]), .skew_out(sf));

  function automatic int lv(input logic [1:0] v);
    return (v == 2'd3) ? 1 : int'(v);
  endfunction

  function automatic int e_div(input logic [1:0] h, input logic [1:0] l);
    int idx;
    idx = lv(h) * 3 + lv(l);
    case (idx)
      0: return 1;  1: return 2;  2: return 3;
      3: return 4;  4: return 5;  5: return 6;
      6: return 8;  7: return 10; default: return 12;
    endcase
  endfunction

  function automatic int e_skew(input int kind, input logic [1:0] h, input logic [1:0] l,
                                input int f1, input int f2);
    int idx;
    idx = lv(h) * 3 + lv(l);
    if (kind == 2) return (lv(l) == 0) ? -4 : ((lv(l) == 2) ? 4 : 0);
    if (kind == 0) return idx - 4;
    case (idx)
      0: return -8; 1: return -7; 2: return -6;
      3: return f1; 4: return 0;  5: return f2;
      6: return 6;  7: return 7;  default: return 8;
    endcase
  endfunction

  function automatic logic [3:0] e_q(input int p, input int per, input int sk, input logic [1:0] v);
    int d;
    logic h, t, c;
    d = (((p - sk) % per) + per) % per;
    h = (d < per / 2);
    t = h ^ (lv(v) == 2);
    c = h ^ ((lv(v) == 2) || (lv(v) == 0));
    return {c, t, c, t};
  endfunction

  task automatic chk4(input string req, input string what, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic chki(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Generic scenario: reset, configure, drive aligns every N ticks, compare every cycle.
  task automatic run_case(input string req, input logic [1:0] rg, input logic [1:0] dhh,
                          input logic [1:0] dll, input logic [1:0] shh, input logic [1:0] sll,
                          input logic [1:0] ivv, input int f1, input int f2, input int chg,
                          input logic [1:0] sh2, input logic [1:0] sl2);
    int n, per, ncyc, ea, hcount;
    int k0x, k0s, k0f, k1x, k1s, k1f;
    n    = 16 << lv(rg);
    per  = n * e_div(dhh, dll);
    ncyc = 2 * per + n + 4;
    ea   = (chg < 0) ? 32'h3fffffff : ((chg + n - 1) / n) * n;
    k0x = e_skew(1, shh, sll, f1, f2); k1x = e_skew(1, sh2, sl2, f1, f2);
    k0s = e_skew(0, shh, sll, f1, f2); k1s = e_skew(0, sh2, sl2, f1, f2);
    k0f = e_skew(2, shh, sll, f1, f2); k1f = e_skew(2, sh2, sl2, f1, f2);
    rst = 1'b1; align = 1'b0;
    rng = rg; dh = dhh; dl = dll; sh = shh; sl = sll; iv = ivv;
    p1 = 5'(f1); p2 = 5'(f2);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    hcount = 0;
    for (int g = 0; g < ncyc; g++) begin
      align = ((g % n) == 0);
      if (g == chg) begin sh = sh2; sl = sl2; end
      if (g >= 2) begin
        int p;
        bit nw;
        p  = g - 2;
        nw = (p >= ea);
        chk4(req, "ext outputs", qx, e_q(p, per, nw ? k1x : k0x, ivv));
        chk4(req, "std outputs", qs, e_q(p, per, nw ? k1s : k0s, ivv));
        chk4(req, "fb outputs",  qf, e_q(p, per, nw ? k1f : k0f, ivv));
        if (g < 2 + per) hcount += int'(qs[0] ^ (lv(ivv) == 2));
      end
      if (g >= 1) begin
        bit nw2;
        nw2 = ((g - 1) >= ea);
        chki(req, "ext skew_out", int'(sx), nw2 ? k1x : k0x);
        chki(req, "std skew_out", int'(ss), nw2 ? k1s : k0s);
        chki(req, "fb skew_out",  int'(sf), nw2 ? k1f : k0f);
      end
      @(posedge clk);
      @(negedge clk);
    end
    align = 1'b0;
    chki("R3", "high ticks per period", hcount, per / 2); // R3 duty
  endtask

  task automatic t_reset; // R1
    rst = 1'b1; align = 1'b1; rng = 2'd2; dh = 2'd2; dl = 2'd2;
    sh = 2'd2; sl = 2'd2; iv = 2'd2; p1 = 5'sd3; p2 = -5'sd3;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk4("R1", "ext outputs in reset", qx, 4'b0000);
    chk4("R1", "std outputs in reset", qs, 4'b0000);
    chk4("R1", "fb outputs in reset",  qf, 4'b0000);
    chki("R1", "ext skew_out in reset", int'(sx), 0);
    chki("R1", "std skew_out in reset", int'(ss), 0);
    chki("R1", "fb skew_out in reset",  int'(sf), 0);
    align = 1'b0;
  endtask

  task automatic t_div_sweep; // R2
    for (int h = 0; h < 3; h++)
      for (int l = 0; l < 3; l++)
        run_case("R2", 2'd0, 2'(h), 2'(l), 2'd1, 2'd1, 2'd1, 0, 0, -1, 2'd1, 2'd1);
    run_case("R9 div", 2'd0, 2'd3, 2'd3, 2'd1, 2'd1, 2'd1, 0, 0, -1, 2'd1, 2'd1);
  endtask

  task automatic t_skew_sweep; // R4 R5 R6
    for (int h = 0; h < 3; h++)
      for (int l = 0; l < 3; l++)
        run_case("R4/R5/R6 skew", 2'd1, 2'd0, 2'd1, 2'(h), 2'(l), 2'd1, -3, 5, -1, 2'd1, 2'd1);
  endtask

  task automatic t_follow; // R5
    run_case("R5 peer1", 2'd2, 2'd0, 2'd0, 2'd1, 2'd0, 2'd1, 8, -8, -1, 2'd1, 2'd0);
    run_case("R5 peer2", 2'd2, 2'd0, 2'd0, 2'd1, 2'd2, 2'd1, 8, -8, -1, 2'd1, 2'd2);
  endtask

  task automatic t_range; // R7
    run_case("R7 high", 2'd2, 2'd0, 2'd2, 2'd2, 2'd2, 2'd1, 0, 0, -1, 2'd2, 2'd2);
    run_case("R7 code3", 2'd3, 2'd0, 2'd0, 2'd0, 2'd0, 2'd1, 0, 0, -1, 2'd0, 2'd0); // R9
  endtask

  task automatic t_invert; // R8
    run_case("R8 compl", 2'd0, 2'd1, 2'd0, 2'd1, 2'd0, 2'd0, 2, -2, -1, 2'd1, 2'd0);
    run_case("R8 all",   2'd0, 2'd1, 2'd0, 2'd1, 2'd0, 2'd2, 2, -2, -1, 2'd1, 2'd0);
    run_case("R9 inv3",  2'd0, 2'd1, 2'd0, 2'd3, 2'd0, 2'd3, 2, -2, -1, 2'd3, 2'd0);
  endtask

  task automatic t_latency; // R11
    run_case("R11", 2'd0, 2'd0, 2'd0, 2'd1, 2'd1, 2'd1, 0, 0, -1, 2'd1, 2'd1);
    run_case("R11 neg", 2'd0, 2'd0, 2'd1, 2'd0, 2'd0, 2'd1, 0, 0, -1, 2'd0, 2'd0);
  endtask

  task automatic t_hold; // R10
    run_case("R10", 2'd1, 2'd0, 2'd2, 2'd1, 2'd1, 2'd1, 0, 0, 40, 2'd2, 2'd0);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; align = 1'b0; rng = 2'd1; dh = 2'd0; dl = 2'd0;
    sh = 2'd1; sl = 2'd1; iv = 2'd1; p1 = '0; p2 = '0;
    t_reset();
    t_div_sweep();
    t_skew_sweep();
    t_follow();
    t_range();
    t_invert();
    t_latency();
    t_hold();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule